// File: doc/BRIEF.md
# Two-Cell Programmable AND-OR Logic Array

This block is a small field-configurable logic fabric with two external inputs and two output cells. Each output cell owns four product terms. Each term is an AND of any chosen subset of eight literals: the true and complemented forms of input A, input B and the two cell outputs, which are fed back. The OR of a cell's four terms passes through optional inversion. It then goes either straight to the pin or through a rising-edge flip-flop, and an enable bit can hold the pin low.

The whole personality is one 70-bit word. It is captured while a load strobe is high and held otherwise. This lets the same instance act as a gate, a latch-free state machine or a counter bit, depending on what is written. The feedback taps sit after the output select, so a registered cell that reads its own complement toggles on every clock.

Top module: `gal_array2`

## Requirements
- R1: Each term sees eight literal columns. Bit k of a row's fuse byte selects column k, in the order A, ~A, B, ~B, X, ~X, Y, ~Y (bit 0 to bit 7). Row r of cell c sits at config bits c*32 + r*8 +: 8, with X as cell 0 and Y as cell 1.
- R2: A fuse bit of 1 (intact) puts its column into that row's AND, and a fuse bit of 0 leaves it out. For example, a row with only A intact gives A, and a row with A and B intact gives A AND B.
- R3: A row whose eight fuse bits are all 0 evaluates to 1.
- R4: A row that includes both the true and complement column of any one signal evaluates to 0. A row with every fuse bit at 1 is therefore 0.
- R5: Mode bit 2 (enable) of a cell at 0 forces that cell's output to 0, whatever its terms and other mode bits are.
- R6: Mode bit 0 at 1 makes the output the value held in a flip-flop loaded on the rising clock edge. At 0 the output follows the terms without waiting for a clock.
- R7: Mode bit 1 at 1 inverts the OR of the cell's terms before the register and the output select.
- R8: The 70-bit config word is captured on a rising edge while the load strobe is 1 and held while it is 0. Fuses for cell 0 are at [31:0], fuses for cell 1 at [63:32], mode bits for cell 0 at [66:64] and mode bits for cell 1 at [69:67].
- R9: A low rst_ni clears both flip-flops and the config word at once, so both outputs read 0.
- R10: The X and Y feedback columns carry the cell outputs after the output select. A registered cell with a single ~X term toggles every cycle.
- R11: A cell's output, before inversion, is the OR of its four product terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output flip-flops and the config capture |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 1 | External input A |
| b_i | input | 1 | External input B |
| cfg_load_i | input | 1 | Config capture strobe |
| cfg_data_i | input | 70 | Fuse and mode word |
| x_o | output | 1 | Output of cell 0 |
| y_o | output | 1 | Output of cell 1 |

## Verification
The hardest case to reach is a registered cell whose next state depends on its own fed-back output. The value loaded on each edge depends on the previous edge, so the cell only shows the correct sequence once the config word has been captured and the flip-flop has started from a known point. The bench reaches this case by loading a toggle personality and letting it run for several cycles. A cycle-accurate model of the product-term equations runs in step with it and tracks both flip-flops, including the capture that happens on the load edge itself. The bench also holds a registered cell's input steady across an edge to show that the output changes only after the edge.

// File: rtl/gal_pkg.sv
package gal_pkg;
  localparam int NUM_IN   = 2;
  localparam int NUM_CELL = 2;
  localparam int MODE_W   = 3;
  localparam int ROWS_DEF = 4;

  typedef struct packed {
    logic en;
    logic inv;
    logic reg_sel;
  } cell_mode_t;
endpackage

// File: rtl/gal_pterm.sv
module gal_pterm #(
  parameter int NUM_COL = 8
) (
  input  logic [NUM_COL-1:0] fuse_i,
  input  logic [NUM_COL-1:0] col_i,
  output logic               term_o
);
  // blown fuse (0) drops the column from the AND
  assign term_o = &(col_i | ~fuse_i);
endmodule

// File: rtl/gal_macrocell.sv
module gal_macrocell
  import gal_pkg::*;
#(
  parameter int NUM_ROW = 4,
  parameter int NUM_COL = 8,
  localparam int FUSE_W = NUM_ROW * NUM_COL
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cell_mode_t         mode_i,
  input  logic [FUSE_W-1:0]  fuse_i,
  input  logic [NUM_COL-1:0] col_i,
  output logic               out_o
);
  localparam logic [NUM_COL-1:0] EVEN_MASK = {(NUM_COL/2){2'b01}};

  logic [NUM_ROW-1:0] term_w;
  logic               sum_w;
  logic               pol_w;
  logic               q_q;

  for (genvar r = 0; r < NUM_ROW; r++) begin : g_row
    logic [NUM_COL-1:0] row_f;
    assign row_f = fuse_i[r*NUM_COL +: NUM_COL];

    gal_pterm #(.NUM_COL(NUM_COL)) u_pt (
      .fuse_i (row_f),
      .col_i  (col_i),
      .term_o (term_w[r])
    );

    a_r3_blown_row_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (row_f == '0) |-> term_w[r]);
    a_r4_pair_row_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(row_f & (row_f >> 1) & EVEN_MASK)) |-> !term_w[r]);
  end

  assign sum_w = |term_w;
  assign pol_w = sum_w ^ mode_i.inv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= pol_w;
  end

  always_comb begin
    if (!mode_i.en)         out_o = 1'b0;
    else if (mode_i.reg_sel) out_o = q_q;
    else                    out_o = pol_w;
  end

  a_r5_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i.en |-> !out_o);
  a_r6_reg_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.en && mode_i.reg_sel && $past(mode_i.en && mode_i.reg_sel))
      |-> (out_o == $past(pol_w)));
  a_r11_term_drives_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.en && !mode_i.reg_sel && !mode_i.inv && term_w[0]) |-> out_o);
  a_r7_inverted_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.en && !mode_i.reg_sel && mode_i.inv && term_w[0]) |-> !out_o);
endmodule

// File: rtl/gal_array2.sv
module gal_array2
  import gal_pkg::*;
#(
  parameter int  NUM_ROW = ROWS_DEF,
  localparam int NUM_SIG = NUM_IN + NUM_CELL,
  localparam int NUM_COL = 2 * NUM_SIG,
  localparam int FUSE_W  = NUM_ROW * NUM_COL,
  localparam int CFG_W   = NUM_CELL * (FUSE_W + MODE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             cfg_load_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic             x_o,
  output logic             y_o
);
  logic [CFG_W-1:0]    cfg_q;
  logic [NUM_CELL-1:0] cell_out;
  logic [NUM_SIG-1:0]  sig_w;
  logic [NUM_COL-1:0]  cols_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= '0;
    else if (cfg_load_i) cfg_q <= cfg_data_i;
  end

  // signal order A, B, X, Y; each gives a true then a complement column
  assign sig_w = {cell_out, b_i, a_i};

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_col
    assign cols_w[2*s]   = sig_w[s];
    assign cols_w[2*s+1] = ~sig_w[s];
  end

  for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell
    cell_mode_t mode_w;
    assign mode_w = cell_mode_t'(cfg_q[NUM_CELL*FUSE_W + c*MODE_W +: MODE_W]);

    gal_macrocell #(.NUM_ROW(NUM_ROW), .NUM_COL(NUM_COL)) u_mc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_w),
      .fuse_i (cfg_q[c*FUSE_W +: FUSE_W]),
      .col_i  (cols_w),
      .out_o  (cell_out[c])
    );
  end

  assign x_o = cell_out[0];
  assign y_o = cell_out[1];

  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(cfg_q));
  a_r8_cfg_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (cfg_q == $past(cfg_data_i)));
  a_r10_feedback_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cols_w[4] != cols_w[5]) && (cols_w[4] == x_o));
endmodule

// File: tb/sim_gal_array2.sv
module sim_gal_array2;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_i = 1'b0, b_i = 1'b0, cfg_load_i = 1'b0;
  logic [69:0] cfg_data_i = '0;
  logic        x_o, y_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [69:0] m_cfg = '0;
  logic        m_qx = 1'b0, m_qy = 1'b0;
  logic        m_ox, m_oy, m_px, m_py;

  always #5 clk_i = ~clk_i;

  gal_array2 u0 (.*);

  // {x_rows, y_rows, x_mode, y_mode, a, b, exp_x, exp_y}; mode = {en, inv, reg}
  localparam int NV = 12;
  localparam logic [73:0] VEC [NV] = '{
    {32'hFFFFFF01, 32'hFFFFFF02, 3'b100, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'hFFFFFF01, 32'hFFFFFF02, 3'b100, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'hFFFFFF05, 32'hFFFFFF0A, 3'b100, 3'b100, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'hFFFFFF05, 32'hFFFFFF0A, 3'b100, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'hFFFFFF05, 32'hFFFFFF0A, 3'b100, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hFFFFFF00, 32'hFFFFFFFF, 3'b100, 3'b100, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'hFFFF0609, 32'hFFFF0609, 3'b100, 3'b110, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'hFFFF0609, 32'hFFFF0609, 3'b100, 3'b110, 1'b1, 1'b1, 1'b0, 1'b1},
    {32'hFFFFFF00, 32'hFFFFFFFF, 3'b000, 3'b010, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hFFFFFF01, 32'hFFFFFF20, 3'b100, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'hFFFFFF03, 32'hFFFFFFFF, 3'b100, 3'b110, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'hFFFFFF40, 32'hFFFFFF04, 3'b100, 3'b100, 1'b0, 1'b1, 1'b1, 1'b1}
  };
  string tags [NV] = '{"R2", "R2", "R2", "R2", "R2", "R3", "R11", "R7",
                       "R5", "R10", "R4", "R1"};

  function automatic logic [69:0] mk_cfg(logic [31:0] xr, logic [31:0] yr,
                                         logic [2:0] xm, logic [2:0] ym);
    return {ym, xm, yr, xr};
  endfunction

  function automatic logic sum4(logic [31:0] rows, logic [7:0] cols);
    logic s = 1'b0;
    for (int r = 0; r < 4; r++) s |= &(cols | ~rows[r*8 +: 8]);
    return s;
  endfunction

  task automatic eval();
    logic [7:0] cols;
    m_ox = 1'b0; m_oy = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cols = {~m_oy, m_oy, ~m_ox, m_ox, ~b_i, b_i, ~a_i, a_i};
      m_px = sum4(m_cfg[31:0], cols) ^ m_cfg[65];
      m_py = sum4(m_cfg[63:32], cols) ^ m_cfg[68];
      m_ox = m_cfg[66] ? (m_cfg[64] ? m_qx : m_px) : 1'b0;
      m_oy = m_cfg[69] ? (m_cfg[67] ? m_qy : m_py) : 1'b0;
    end
  endtask

  task automatic check(logic cond, string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual xy=%b expected xy=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(logic ld, logic [69:0] data, logic a, logic b);
    @(negedge clk_i);
    cfg_load_i = ld; cfg_data_i = data; a_i = a; b_i = b;
    #1;
  endtask

  task automatic check_model(string tag);
    eval();
    check({x_o, y_o} === {m_ox, m_oy}, tag, {x_o, y_o}, {m_ox, m_oy});
  endtask

  task automatic edge_update();
    logic ld;
    logic [69:0] d;
    eval();
    ld = cfg_load_i; d = cfg_data_i;
    @(posedge clk_i);
    m_qx = m_px; m_qy = m_py;
    if (ld) m_cfg = d;
  endtask

  task automatic step(logic ld, logic [69:0] data, logic a, logic b, string tag);
    drive(ld, data, a, b);
    check_model(tag);
    edge_update();
  endtask

  initial begin
    logic [69:0] cfg;
    logic        prev_x;
    repeat (3) @(posedge clk_i);
    #1;
    check({x_o, y_o} === 2'b00, "R9 reset", {x_o, y_o}, 2'b00);
    @(negedge clk_i) rst_ni = 1'b1;

    // table walk: load a personality, then compare with table and model
    for (int i = 0; i < NV; i++) begin
      cfg = mk_cfg(VEC[i][73:42], VEC[i][41:10], VEC[i][9:7], VEC[i][6:4]);
      step(1'b1, cfg, VEC[i][3], VEC[i][2], "R8 load");
      drive(1'b0, cfg, VEC[i][3], VEC[i][2]);
      check({x_o, y_o} === VEC[i][1:0], tags[i], {x_o, y_o}, VEC[i][1:0]);
      check_model(tags[i]);
      edge_update();
    end

    // R6: registered X follows A only after an edge; Y combinational A
    cfg = mk_cfg(32'hFFFFFF01, 32'hFFFFFF01, 3'b101, 3'b100);
    step(1'b1, cfg, 1'b0, 1'b0, "R6");
    step(1'b0, cfg, 1'b0, 1'b0, "R6");
    drive(1'b0, cfg, 1'b1, 1'b0);
    check({x_o, y_o} === 2'b01, "R6 before edge", {x_o, y_o}, 2'b01);
    edge_update();
    drive(1'b0, cfg, 1'b1, 1'b0);
    check({x_o, y_o} === 2'b11, "R6 after edge", {x_o, y_o}, 2'b11);
    edge_update();

    // R8: new word without strobe must not take effect
    drive(1'b0, '0, 1'b1, 1'b0);
    check({x_o, y_o} === 2'b11, "R8 hold", {x_o, y_o}, 2'b11);
    check_model("R8");
    edge_update();

    // R10: registered X with a single ~X term toggles; Y mirrors X
    cfg = mk_cfg(32'hFFFFFF20, 32'hFFFFFF10, 3'b101, 3'b100);
    step(1'b1, cfg, 1'b0, 1'b0, "R10");
    drive(1'b0, cfg, 1'b0, 1'b0);
    prev_x = x_o;
    edge_update();
    for (int k = 0; k < 6; k++) begin
      drive(1'b0, cfg, k[0], k[1]);
      check(x_o !== prev_x, "R10 toggle", {x_o, y_o}, {~prev_x, ~prev_x});
      check(y_o === x_o, "R10 feedback", {x_o, y_o}, {x_o, x_o});
      check_model("R10");
      prev_x = x_o;
      edge_update();
    end

    // R9: reset in mid-run clears outputs at once
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    check({x_o, y_o} === 2'b00, "R9 mid-run", {x_o, y_o}, 2'b00);
    m_cfg = '0; m_qx = 1'b0; m_qy = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    step(1'b0, cfg, 1'b1, 1'b1, "R9 after");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule